// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is an up/down counter with a single compare channel. It turns the relation between the running count and a compare value into a waveform on one output line. A two-bit mode input picks how the counter runs: free-running or clear-on-match, a single-slope sawtooth for fast PWM, or a triangle that rises and falls for phase-correct PWM. A second two-bit output code sets the effect of a compare match on the output line in that counting mode. A top-select bit chooses whether the counter turns at its all-ones value or at the compare value.

The compare value reaches the comparator directly in the non-PWM mode. In the two PWM modes it passes through a holding register, so a duty-cycle update never tears a running period. Two one-cycle strobes report a compare match and a counter overflow. A flag tells the surrounding pad logic when the waveform should replace the pin's ordinary function. The pad keeps its own output-enable, so a driven pin also needs its direction bit set outside this block.

Top module: `tmr_wave_unit`

## Requirements
- R1: While `rstN` is low, `cntOut` is 0 and `waveOut` is 0. With `enable` low, both strobes are 0. The triangle direction resets to rising and the held compare value resets to 0.
- R2: While `enable` is low, the count holds, `waveOut` holds, and `matchStrobe` and `ovfStrobe` stay 0.
- R3: With output code 2'b00, `overrideEn` is 0 and `waveOut` never changes. Every code with a nonzero bit sets `overrideEn` to 1, except the case in R7.
- R4: With `genMode` 2'b00 (or 2'b11), codes 01, 10 and 11 toggle, clear and set `waveOut` on a match. The count wraps from all-ones to 0. With `topSel` 1 it returns to 0 in the cycle after it equals the compare value.
- R5: With `genMode` 2'b01 (fast PWM), the count runs 0 up to TOP and then returns to 0. TOP is all-ones when `topSel` is 0 and the held compare value when `topSel` is 1.
- R6: In fast PWM, code 10 sets `waveOut` at count 0 and clears it on a match. Code 11 does the reverse. When the count is 0 and also matches, the match action wins.
- R7: In either PWM mode, code 01 toggles `waveOut` on a match when `topSel` is 1. When `topSel` is 0 it leaves the pin disconnected: `overrideEn` is 0 and `waveOut` holds.
- R8: With `genMode` 2'b10 (phase-correct), the count rises from 0 to TOP, falls back to 0 and rises again. The value after TOP is TOP-1 and the value after 0 is 1. TOP is chosen as in R5.
- R9: In phase-correct PWM, a match with the next step rising clears `waveOut` under code 10 and sets it under code 11. With the next step falling, the actions swap.
- R10: With code 10 or 11, when the compare value equals TOP, fast PWM drops the match action and keeps only the action at count 0. Phase-correct PWM applies the falling-step action at TOP.
- R11: The compare value used by the non-PWM mode follows `cmpIn` in the same cycle. Fast PWM takes a new `cmpIn` when the count leaves TOP, so it is first used from count 0. Phase-correct PWM takes it when the count turns at TOP.
- R12: `matchStrobe` is high for one cycle in each enabled cycle where the count equals the compare value in use. `ovfStrobe` is high for one cycle when the count is all-ones (non-PWM), when it is at TOP (fast PWM), or when it is at 0 (phase-correct).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Count enable; the count advances one step per enabled cycle |
| genMode | input | 2 | Counting mode: 00 non-PWM, 01 fast PWM, 10 phase-correct PWM, 11 non-PWM |
| topSel | input | 1 | 0: TOP is all-ones; 1: TOP is the compare value |
| outCode | input | 2 | Compare output code |
| cmpIn | input | CNT_W | Compare value |
| cntOut | output | CNT_W | Current count |
| waveOut | output | 1 | Waveform output register |
| overrideEn | output | 1 | High when the waveform should replace the pin's ordinary function |
| ovfStrobe | output | 1 | One-cycle overflow strobe |
| matchStrobe | output | 1 | One-cycle compare match strobe |

## Verification
The bench runs every output code in each counting mode. It measures the high time and the strobe counts over a whole number of periods. The inverting and non-inverting codes give duties that add up to one period, so a swapped polarity shows up at once. The two phase-correct codes give twice the compare value against the rest of the period, which separates rising-step actions from falling-step ones. Compare values of 0 and TOP probe the match-versus-bottom priority and the TOP special case. The top-select variants show whether TOP is taken from the compare value. Directed runs change the compare value mid-period, which tells immediate use apart from buffered use.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_SAW    = 2'b01,
    MODE_TRI    = 2'b10,
    MODE_SPARE  = 2'b11
  } waveMode_e;

  // Events the counter control hands to the output datapath each cycle
  typedef struct packed {
    logic hit;       // enabled cycle with count equal to the active compare value
    logic atBottom;  // enabled cycle with count at zero
    logic stepDown;  // triangle mode: the next step lowers the count
    logic cmpIsTop;  // active compare value equals TOP
  } cmpEvents_t;

endpackage

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  waveMode_e        mode,
  input  logic             topSel,
  input  logic [CNT_W-1:0] cmpIn,
  output logic [CNT_W-1:0] cnt,
  output cmpEvents_t       ev,
  output logic             ovf,
  output logic             match
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

  logic [CNT_W-1:0] cntQ, cntNext, cmpBufQ, cmpAct, topVal;
  logic             dirDownQ, dirNext, upStep;
  logic             isTri, isSaw, isDirect, atTop, atZero, loadBuf, topIsZero;

  always_comb begin
    isTri     = (mode == MODE_TRI);
    isSaw     = (mode == MODE_SAW);
    isDirect  = !isTri && !isSaw;
    cmpAct    = isDirect ? cmpIn : cmpBufQ;
    topVal    = topSel ? cmpAct : MAXV;
    topIsZero = (topVal == ZERO);
    atTop     = (cntQ == topVal);
    atZero    = (cntQ == ZERO);
    upStep    = dirDownQ ? atZero : !atTop;

    if (isTri) begin
      if (topIsZero) begin
        cntNext = ZERO;
        dirNext = 1'b0;
      end else begin
        cntNext = upStep ? cntQ + 1'b1 : cntQ - 1'b1;
        dirNext = !upStep;
      end
    end else begin
      cntNext = atTop ? ZERO : cntQ + 1'b1;
      dirNext = 1'b0;
    end

    loadBuf = isDirect || (enable && atTop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= ZERO;
      dirDownQ <= 1'b0;
      cmpBufQ  <= ZERO;
    end else begin
      if (enable) begin
        cntQ     <= cntNext;
        dirDownQ <= dirNext;
      end
      if (loadBuf) cmpBufQ <= cmpIn;
    end
  end

  always_comb begin
    match       = enable && (cntQ == cmpAct);
    ovf         = enable && (isTri ? atZero : (isSaw ? atTop : (cntQ == MAXV)));
    ev.hit      = match;
    ev.atBottom = enable && atZero;
    ev.stepDown = isTri && !topIsZero && !upStep;
    ev.cmpIsTop = (cmpAct == topVal);
    cnt         = cntQ;
  end

  // R2: a disabled cycle leaves the count where it was
  assert_hold_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(cntQ))
    else $error("count moved while disabled");

  // R5: sawtooth returns to zero after TOP
  assert_saw_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (isSaw && enable && atTop) |=> (cntQ == ZERO))
    else $error("sawtooth did not wrap at TOP");

  // R8: triangle turns at TOP and steps down by one
  assert_tri_turn_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isTri && enable && atTop && !topIsZero) |=> (cntQ == CNT_W'($past(topVal) - 1'b1)))
    else $error("triangle did not turn at TOP");

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
  import tmr_wave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  waveMode_e  mode,
  input  logic       topSel,
  input  logic [1:0] outCode,
  input  cmpEvents_t ev,
  output logic       waveOut,
  output logic       overrideEn
);

  logic waveQ, waveNext, isPwm, linked;

  always_comb begin
    isPwm    = (mode == MODE_SAW) || (mode == MODE_TRI);
    linked   = (outCode != 2'b00) && !(isPwm && (outCode == 2'b01) && !topSel);
    waveNext = waveQ;
    if (linked) begin
      if (outCode == 2'b01) begin
        if (ev.hit) waveNext = !waveQ;
      end else begin
        case (mode)
          MODE_SAW: begin
            if (ev.atBottom) waveNext = !outCode[0];
            if (ev.hit && !ev.cmpIsTop) waveNext = outCode[0];
          end
          MODE_TRI: begin
            if (ev.hit) waveNext = ev.stepDown ? !outCode[0] : outCode[0];
          end
          default: begin
            if (ev.hit) waveNext = outCode[0];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) waveQ <= 1'b0;
    else       waveQ <= waveNext;
  end

  assign waveOut    = waveQ;
  assign overrideEn = linked;

  // R3: a disconnected code never moves the output register
  assert_code_off_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outCode == 2'b00) |=> $stable(waveQ))
    else $error("output moved with code 00");

  // R7: toggle code without top-select in PWM leaves the output alone
  assert_toggle_off_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isPwm && outCode == 2'b01 && !topSel) |=> $stable(waveQ))
    else $error("output moved while toggle code disconnected");

  // R6: non-inverting sawtooth clears on an ordinary match
  assert_saw_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SAW && outCode == 2'b10 && ev.hit && !ev.cmpIsTop) |=> !waveQ)
    else $error("sawtooth match did not clear");

  // R9: code 10 clears on a match taken on a rising step
  assert_tri_up_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TRI && outCode == 2'b10 && ev.hit && !ev.stepDown) |=> !waveQ)
    else $error("triangle rising match did not clear");

endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       genMode,
  input  logic             topSel,
  input  logic [1:0]       outCode,
  input  logic [CNT_W-1:0] cmpIn,
  output logic [CNT_W-1:0] cntOut,
  output logic             waveOut,
  output logic             overrideEn,
  output logic             ovfStrobe,
  output logic             matchStrobe
);

  waveMode_e  mode;
  cmpEvents_t events;

  assign mode = waveMode_e'(genMode);

  tmr_wave_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .mode   (mode),
    .topSel (topSel),
    .cmpIn  (cmpIn),
    .cnt    (cntOut),
    .ev     (events),
    .ovf    (ovfStrobe),
    .match  (matchStrobe)
  );

  tmr_wave_out u_out (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .topSel     (topSel),
    .outCode    (outCode),
    .ev         (events),
    .waveOut    (waveOut),
    .overrideEn (overrideEn)
  );

endmodule

// File: tb/test_tmr_wave_unit.sv
`timescale 1ns/1ps
module test_tmr_wave_unit;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic [1:0] genMode;
  logic       topSel;
  logic [1:0] outCode;
  logic [7:0] cmpIn;
  logic [7:0] cntOut;
  logic       waveOut, overrideEn, ovfStrobe, matchStrobe;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  tmr_wave_unit #(.CNT_W(8)) i_tmr_wave_unit (
    .clk(clk), .rstN(rstN), .enable(enable), .genMode(genMode), .topSel(topSel),
    .outCode(outCode), .cmpIn(cmpIn), .cntOut(cntOut), .waveOut(waveOut),
    .overrideEn(overrideEn), .ovfStrobe(ovfStrobe), .matchStrobe(matchStrobe)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  code;
    logic        ts;
    logic [7:0]  cmp;
    logic [15:0] win;
    logic [15:0] high;
    logic [7:0]  ovf;
    logic [7:0]  mat;
    logic        ovr;
  } vec_t;

  localparam int NV = 18;
  // mode 0 non-PWM, 1 fast PWM, 2 phase-correct; window covers whole periods
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 1'b0, 8'd37,  16'd512, 16'd256, 8'd2, 8'd2, 1'b1},
    '{2'd0, 2'd2, 1'b0, 8'd37,  16'd256, 16'd0,   8'd1, 8'd1, 1'b1},
    '{2'd0, 2'd3, 1'b0, 8'd37,  16'd256, 16'd256, 8'd1, 8'd1, 1'b1},
    '{2'd0, 2'd1, 1'b1, 8'd20,  16'd42,  16'd21,  8'd0, 8'd2, 1'b1},
    '{2'd1, 2'd2, 1'b0, 8'd100, 16'd256, 16'd100, 8'd1, 8'd1, 1'b1},
    '{2'd1, 2'd3, 1'b0, 8'd100, 16'd256, 16'd156, 8'd1, 8'd1, 1'b1},
    '{2'd1, 2'd2, 1'b0, 8'd0,   16'd256, 16'd0,   8'd1, 8'd1, 1'b1},
    '{2'd1, 2'd2, 1'b0, 8'd255, 16'd256, 16'd256, 8'd1, 8'd1, 1'b1},
    '{2'd1, 2'd1, 1'b0, 8'd99,  16'd256, 16'd0,   8'd1, 8'd1, 1'b0},
    '{2'd1, 2'd1, 1'b1, 8'd99,  16'd200, 16'd100, 8'd2, 8'd2, 1'b1},
    '{2'd2, 2'd2, 1'b0, 8'd100, 16'd510, 16'd200, 8'd1, 8'd2, 1'b1},
    '{2'd2, 2'd3, 1'b0, 8'd100, 16'd510, 16'd310, 8'd1, 8'd2, 1'b1},
    '{2'd2, 2'd2, 1'b0, 8'd0,   16'd510, 16'd0,   8'd1, 8'd1, 1'b1},
    '{2'd2, 2'd2, 1'b0, 8'd255, 16'd510, 16'd510, 8'd1, 8'd1, 1'b1},
    '{2'd2, 2'd1, 1'b1, 8'd60,  16'd240, 16'd120, 8'd2, 8'd2, 1'b1},
    '{2'd2, 2'd2, 1'b1, 8'd60,  16'd240, 16'd240, 8'd2, 8'd2, 1'b1},
    '{2'd2, 2'd1, 1'b0, 8'd60,  16'd510, 16'd0,   8'd1, 8'd2, 1'b0},
    '{2'd0, 2'd0, 1'b0, 8'd37,  16'd256, 16'd0,   8'd1, 8'd1, 1'b0}
  };

  function automatic string dutyTag(input int i);
    case (i)
      0, 1, 2, 3:  return "R4 non-PWM action";
      4, 5, 6:     return "R6 fast PWM duty";
      7:           return "R10 fast compare at TOP";
      8, 9, 14:    return "R7 toggle code in PWM";
      10, 11, 12:  return "R9 phase-correct duty";
      13, 15:      return "R10 phase-correct compare at TOP";
      16:          return "R7 toggle code disconnected";
      default:     return "R3 code 00 output held";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] c, input logic t, input logic [7:0] v);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0;
    genMode = m; outCode = c; topSel = t; cmpIn = v;
    repeat (3) @(negedge clk);
    rstN = 1'b1; enable = 1'b1;
  endtask

  task automatic waitFor(input int v);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (int'(cntOut) == v) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; genMode = 2'd2; topSel = 1'b0; outCode = 2'd3; cmpIn = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cntOut == 8'd0, "R1 count in reset", int'(cntOut), 0);
    check(waveOut == 1'b0, "R1 output in reset", int'(waveOut), 0);
    check(!ovfStrobe && !matchStrobe, "R1 strobes in reset", int'({ovfStrobe, matchStrobe}), 0);

    // Vector table: settle, then measure over a whole number of periods
    for (int i = 0; i < NV; i++) begin
      int hi, ov, mt, ovrBad;
      hi = 0; ov = 0; mt = 0; ovrBad = 0;
      setup(VECS[i].mode, VECS[i].code, VECS[i].ts, VECS[i].cmp);
      repeat (1200) @(negedge clk);
      for (int c = 0; c < int'(VECS[i].win); c++) begin
        @(negedge clk);
        hi += int'(waveOut);
        ov += int'(ovfStrobe);
        mt += int'(matchStrobe);
        if (overrideEn != VECS[i].ovr) ovrBad++;
      end
      check(hi == int'(VECS[i].high), dutyTag(i), hi, int'(VECS[i].high));
      check(ov == int'(VECS[i].ovf), "R12 overflow count", ov, int'(VECS[i].ovf));
      check(mt == int'(VECS[i].mat), "R12 match count", mt, int'(VECS[i].mat));
      check(ovrBad == 0, VECS[i].ovr ? "R3 override flag set" : "R7 override flag clear",
            int'(overrideEn), int'(VECS[i].ovr));
    end

    // R2: hold while disabled
    begin
      int strobes;
      strobes = 0;
      setup(2'd1, 2'd2, 1'b0, 8'd100);
      repeat (600) @(negedge clk);
      waitFor(50);
      enable = 1'b0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        strobes += int'(ovfStrobe) + int'(matchStrobe);
      end
      check(cntOut == 8'd50, "R2 count held", int'(cntOut), 50);
      check(waveOut == 1'b1, "R2 output held", int'(waveOut), 1);
      check(strobes == 0, "R2 strobes quiet", strobes, 0);
      enable = 1'b1;
    end

    // R5: sawtooth with TOP from compare value returns to zero after TOP
    setup(2'd1, 2'd2, 1'b1, 8'd40);
    repeat (200) @(negedge clk);
    waitFor(40);
    @(negedge clk);
    check(cntOut == 8'd0, "R5 wrap after TOP", int'(cntOut), 0);

    // R8: triangle turning points
    setup(2'd2, 2'd2, 1'b0, 8'd100);
    waitFor(255);
    @(negedge clk);
    check(cntOut == 8'd254, "R8 step after TOP", int'(cntOut), 254);
    waitFor(0);
    @(negedge clk);
    check(cntOut == 8'd1, "R8 step after zero", int'(cntOut), 1);

    // R11: fast PWM compare buffered until the next period
    setup(2'd1, 2'd2, 1'b0, 8'd50);
    repeat (600) @(negedge clk);
    waitFor(100);
    cmpIn = 8'd200;
    waitFor(200);
    check(matchStrobe == 1'b0, "R11 fast new compare not yet used", int'(matchStrobe), 0);
    waitFor(0);
    waitFor(200);
    check(matchStrobe == 1'b1, "R11 fast new compare used next period", int'(matchStrobe), 1);

    // R11: non-PWM compare used at once
    setup(2'd0, 2'd0, 1'b0, 8'd50);
    waitFor(100);
    cmpIn = 8'd200;
    waitFor(200);
    check(matchStrobe == 1'b1, "R11 non-PWM compare immediate", int'(matchStrobe), 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule